// File: doc/BRIEF.md
# MESI Line State Controller

This block holds the coherence state of every line in a small cache, two bits per line, together with a per-line payload register that stands in for the data array. Each cycle it takes at most one local read or write and at most one snooped transaction from another agent. From the line's state it decides whether the local access finishes inside the cache or needs a system-bus transaction. The possible transactions are an ownership request, a line fill and a direct write. It then updates the line state and answers each snoop with hit, shared and dirty-data indications.

A local request is held by the requester until `localDone` pulses, and `reqBusy` marks every cycle in which it is held without completing. The outgoing bus request stays raised until the bus returns a one-cycle `busAck`. A snoop always takes precedence over local work. In a cycle that carries a snoop, no new local request is evaluated. If a snoop kills a line while an ownership request for that line is outstanding, the local write does not complete on the acknowledge. It goes back and is evaluated again against the new state. A snoop that hits a Modified line returns the dirty payload on the response port, and this return is the line's writeback.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request or snoop response is active, and the first read of any line issues a fill.
- R2: Line states are two bits: Invalid=00, Shared=01, Exclusive=10, Modified=11. A local read of a Shared, Exclusive or Modified line completes in the same cycle with the line's payload on `rdData` and no bus request.
- R3: A local write to an Exclusive or Modified line completes in the same cycle without a bus request, stores the data and leaves the line Modified.
- R4: A local write to a Shared line raises an ownership request (`busReqType`=0). On its acknowledge the write completes in that cycle, the data is stored and the line becomes Modified.
- R5: A local write to an Invalid line raises a direct write (`busReqType`=2) carrying the index and data. It completes on the acknowledge, and the line stays Invalid.
- R6: A local read of an Invalid line raises a fill (`busReqType`=1). On the acknowledge it completes with `busFillData` on `rdData`, and the line becomes Exclusive if `busFillShared` is low, Shared if it is high.
- R7: A snooped read (`snpInv`=0) that hits a valid line answers one cycle later with hit and shared set, and the line becomes Shared. On a Modified line the answer also sets `snpSupply` with the payload on `snpData`.
- R8: A snooped invalidate (`snpInv`=1) that hits a valid line answers one cycle later with hit set and shared clear, and the line becomes Invalid. A Modified line also supplies its payload.
- R9: A snoop of an Invalid line answers with hit, shared and supply all clear and changes nothing.
- R10: A held local request is not evaluated in a cycle that carries a snoop; it stays busy and is evaluated in the next cycle against the post-snoop state.
- R11: If the line of an outstanding ownership request is invalidated by a snoop, the acknowledge does not complete the write; the request is evaluated again and issues a direct write.
- R12: A raised bus request keeps its type until the cycle it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local request present, held until done |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIdx | input | $clog2(LINES) | Line index of the local request |
| reqData | input | DATA_W | Write data |
| reqBusy | output | 1 | Request held but not completing this cycle |
| localDone | output | 1 | Local request completes this cycle |
| rdData | output | DATA_W | Read data, valid with localDone on a read |
| busReqValid | output | 1 | Outgoing bus transaction pending |
| busReqType | output | 2 | 0 ownership, 1 fill, 2 direct write |
| busReqIdx | output | $clog2(LINES) | Line index of the bus transaction |
| busReqData | output | DATA_W | Data of a direct write |
| busAck | input | 1 | One-cycle completion of the bus transaction |
| busFillData | input | DATA_W | Fill data, valid with busAck |
| busFillShared | input | 1 | Another agent keeps a copy of the filled line |
| snpValid | input | 1 | Snooped transaction this cycle |
| snpInv | input | 1 | 1 = invalidate/ownership, 0 = read |
| snpIdx | input | $clog2(LINES) | Snooped line index |
| snpRespValid | output | 1 | Snoop answer, one cycle after the snoop |
| snpHit | output | 1 | Snooped line was valid |
| snpShared | output | 1 | Line stays shared here |
| snpSupply | output | 1 | Dirty payload supplied as writeback |
| snpData | output | DATA_W | Supplied payload |

## Verification
The bench concentrates on collisions between snoops and local work. A snoop in the very cycle a write to an Exclusive line would be evaluated must turn that write into an ownership request; a design that evaluated first would complete silently and leave a stale copy elsewhere. An invalidate during an outstanding ownership request must make the acknowledge re-run the access as a direct write; a design that trusted the acknowledge would mark an Invalid line Modified. It also checks that a write miss never allocates the line, so a later read must still fill, and that the fill's shared bit picks Exclusive or Shared. A wrong choice shows up as a silent write where an ownership request was due, or the reverse.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_e;

  typedef enum logic [1:0] {
    BT_OWN  = 2'd0,
    BT_FILL = 2'd1,
    BT_DWR  = 2'd2
  } busType_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_OWN,
    C_FILL,
    C_DWR
  } ctrlState_e;

  // strobes from control to the line store
  typedef struct packed {
    logic       upd;
    lineState_e newState;
    logic       loadPayload;
    logic       fromFill;
  } lineStrobe_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_ctrl_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       ctrlStb,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpUpd,
  input  logic [IDX_W-1:0]  snpIdx,
  input  lineState_e        snpNewState,
  output lineState_e        localState,
  output logic [DATA_W-1:0] localPayload,
  output lineState_e        snpState,
  output logic [DATA_W-1:0] snpPayload
);

  lineState_e        stateQ   [LINES];
  logic [DATA_W-1:0] payloadQ [LINES];

  // local update wins over snoop on the same index; control only
  // updates a line that the same-cycle snoop leaves valid
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rstN) begin
        stateQ[i]   <= LS_INV;
        payloadQ[i] <= '0;
      end else begin
        if (ctrlStb.upd && reqIdx == IDX_W'(i))
          stateQ[i] <= ctrlStb.newState;
        else if (snpUpd && snpIdx == IDX_W'(i))
          stateQ[i] <= snpNewState;
        if (ctrlStb.loadPayload && reqIdx == IDX_W'(i))
          payloadQ[i] <= ctrlStb.fromFill ? busFillData : reqData;
      end
    end
  end

  assign localState   = stateQ[reqIdx];
  assign localPayload = payloadQ[reqIdx];
  assign snpState     = stateQ[snpIdx];
  assign snpPayload   = payloadQ[snpIdx];

  // R8: a snoop invalidate is never overridden by the local side
  p_snoop_inv_sticks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snpUpd && snpNewState == LS_INV) |=> stateQ[$past(snpIdx)] == LS_INV);

  // R5: the local side never writes the Invalid code (a write miss does not allocate)
  p_ctrl_no_inv_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.upd |-> ctrlStb.newState != LS_INV);

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic              snpInv,
  input  lineState_e        snpState,
  input  logic [DATA_W-1:0] snpPayload,
  output logic              snpUpd,
  output lineState_e        snpNewState,
  output logic              respValid,
  output logic              respHit,
  output logic              respShared,
  output logic              respSupply,
  output logic [DATA_W-1:0] respData
);

  logic lineValid;
  assign lineValid   = snpState != LS_INV;
  assign snpUpd      = snpValid && lineValid;
  assign snpNewState = snpInv ? LS_INV : LS_SHR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respShared <= 1'b0;
      respSupply <= 1'b0;
      respData   <= '0;
    end else begin
      respValid  <= snpValid;
      respHit    <= snpValid && lineValid;
      respShared <= snpValid && lineValid && !snpInv;
      respSupply <= snpValid && snpState == LS_MOD;
      respData   <= (snpValid && snpState == LS_MOD) ? snpPayload : '0;
    end
  end

  // R7: a snoop on a dirty line always supplies data one cycle later
  p_dirty_supplied_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpState == LS_MOD) |=> (respValid && respSupply && respHit));

  // R9: a snoop that misses answers quietly
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpState == LS_INV) |=> (respValid && !respHit && !respShared && !respSupply));

endmodule

// File: rtl/mesi_access_ctrl.sv
module mesi_access_ctrl
  import mesi_ctrl_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic              snpValid,
  input  logic              snpInv,
  input  logic [IDX_W-1:0]  snpIdx,
  input  lineState_e        localState,
  input  logic [DATA_W-1:0] localPayload,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              busFillShared,
  output lineStrobe_t       ctrlStb,
  output logic              busReqValid,
  output logic [1:0]        busReqType,
  output logic              localDone,
  output logic              reqBusy,
  output logic [DATA_W-1:0] rdData
);

  ctrlState_e fsmQ, fsmD;
  logic       rdFromFill;
  logic       snpKillsLine;

  assign snpKillsLine = snpValid && snpInv && snpIdx == reqIdx;

  always_comb begin
    fsmD       = fsmQ;
    ctrlStb    = '0;
    localDone  = 1'b0;
    rdFromFill = 1'b0;
    unique case (fsmQ)
      C_IDLE: begin
        if (reqValid && !snpValid) begin
          if (!reqWrite) begin
            if (localState != LS_INV) localDone = 1'b1;
            else                      fsmD = C_FILL;
          end else if (localState == LS_MOD || localState == LS_EXC) begin
            localDone           = 1'b1;
            ctrlStb.upd         = 1'b1;
            ctrlStb.newState    = LS_MOD;
            ctrlStb.loadPayload = 1'b1;
          end else if (localState == LS_SHR) begin
            fsmD = C_OWN;
          end else begin
            fsmD = C_DWR;
          end
        end
      end
      C_FILL: begin
        if (busAck) begin
          fsmD                = C_IDLE;
          localDone           = 1'b1;
          rdFromFill          = 1'b1;
          ctrlStb.upd         = 1'b1;
          ctrlStb.newState    = busFillShared ? LS_SHR : LS_EXC;
          ctrlStb.loadPayload = 1'b1;
          ctrlStb.fromFill    = 1'b1;
        end
      end
      C_DWR: begin
        if (busAck) begin
          fsmD      = C_IDLE;
          localDone = 1'b1;
        end
      end
      C_OWN: begin
        if (busAck) begin
          fsmD = C_IDLE;
          // a snoop may have taken the line meanwhile: then re-evaluate
          if (localState == LS_SHR && !snpKillsLine) begin
            localDone           = 1'b1;
            ctrlStb.upd         = 1'b1;
            ctrlStb.newState    = LS_MOD;
            ctrlStb.loadPayload = 1'b1;
          end
        end
      end
      default: fsmD = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) fsmQ <= C_IDLE;
    else       fsmQ <= fsmD;
  end

  always_comb begin
    unique case (fsmQ)
      C_OWN:   busReqType = BT_OWN;
      C_FILL:  busReqType = BT_FILL;
      default: busReqType = BT_DWR;
    endcase
  end

  assign busReqValid = fsmQ != C_IDLE;
  assign reqBusy     = reqValid && !localDone;
  assign rdData      = rdFromFill ? busFillData : localPayload;

  // R12: an outstanding bus request holds its type until acknowledged
  p_bus_req_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busAck) |=> (busReqValid && $stable(busReqType)));

  // R3: a write hit on an owned line finishes without bus traffic
  p_silent_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqValid && reqValid && reqWrite && !snpValid &&
     (localState == LS_MOD || localState == LS_EXC)) |-> (localDone && !reqBusy) ##1 !busReqValid);

  // R10: no local completion from idle in a snoop cycle
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqValid && snpValid) |-> !localDone);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_ctrl_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqBusy,
  output logic              localDone,
  output logic [DATA_W-1:0] rdData,
  output logic              busReqValid,
  output logic [1:0]        busReqType,
  output logic [IDX_W-1:0]  busReqIdx,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              busFillShared,
  input  logic              snpValid,
  input  logic              snpInv,
  input  logic [IDX_W-1:0]  snpIdx,
  output logic              snpRespValid,
  output logic              snpHit,
  output logic              snpShared,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);

  lineStrobe_t       ctrlStb;
  lineState_e        localState, snpState, snpNewState;
  logic [DATA_W-1:0] localPayload, snpPayload;
  logic              snpUpd;

  mesi_line_store #(.LINES(LINES), .DATA_W(DATA_W)) store_i (
    .clk, .rstN, .ctrlStb, .reqIdx, .reqData, .busFillData,
    .snpUpd, .snpIdx, .snpNewState,
    .localState, .localPayload, .snpState, .snpPayload
  );

  mesi_snoop_resp #(.DATA_W(DATA_W)) snoop_i (
    .clk, .rstN, .snpValid, .snpInv, .snpState, .snpPayload,
    .snpUpd, .snpNewState,
    .respValid(snpRespValid), .respHit(snpHit), .respShared(snpShared),
    .respSupply(snpSupply), .respData(snpData)
  );

  mesi_access_ctrl #(.LINES(LINES), .DATA_W(DATA_W)) ctrl_i (
    .clk, .rstN, .reqValid, .reqWrite, .reqIdx, .snpValid, .snpInv, .snpIdx,
    .localState, .localPayload, .busAck, .busFillData, .busFillShared,
    .ctrlStb, .busReqValid, .busReqType, .localDone, .reqBusy, .rdData
  );

  assign busReqIdx  = reqIdx;
  assign busReqData = reqData;

endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;

  localparam int LINES = 8;
  localparam int IW    = 3;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic [DW-1:0] reqData = '0;
  logic          reqBusy, localDone;
  logic [DW-1:0] rdData;
  logic          busReqValid;
  logic [1:0]    busReqType;
  logic [IW-1:0] busReqIdx;
  logic [DW-1:0] busReqData;
  logic          busAck = 1'b0;
  logic [DW-1:0] busFillData = '0;
  logic          busFillShared = 1'b0;
  logic          snpValid = 1'b0, snpInv = 1'b0;
  logic [IW-1:0] snpIdx = '0;
  logic          snpRespValid, snpHit, snpShared, snpSupply;
  logic [DW-1:0] snpData;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES), .DATA_W(DW)) dut_i (.*);

  int    nChecks = 0, nFails = 0;
  string phase = "R1";
  int    ackDelay = 1;
  bit    shareNext = 1'b0;
  int    cycleNo = 0;

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // bus responder: acknowledge after ackDelay cycles of a raised request
  int waitCnt = 0;
  always @(negedge clk) begin
    cycleNo++;
    if (busAck || !rstN || !busReqValid) begin
      busAck  = 1'b0;
      waitCnt = 0;
    end else if (waitCnt >= ackDelay) begin
      busAck        = 1'b1;
      busFillData   = 32'hF111_0000 + cycleNo;
      busFillShared = shareNext;
    end else begin
      waitCnt++;
    end
  end

  // reference model: state codes 0=I 1=S 2=E 3=M; pend 0 none,1 own,2 fill,3 dwr
  int            mSt [LINES];
  logic [DW-1:0] mD  [LINES];
  int            mPend = 0;
  bit            pValid = 0, pHit = 0, pShr = 0, pSup = 0;
  logic [DW-1:0] pData = '0;

  always @(negedge clk) begin
    #1;
    if (!rstN) begin
      foreach (mSt[i]) begin mSt[i] = 0; mD[i] = '0; end
      mPend = 0; pValid = 0; pHit = 0; pShr = 0; pSup = 0; pData = '0;
    end else begin
      bit            eDone, wEn;
      int            nPend, wSt, ri, si, ss;
      logic [DW-1:0] eRd, wD;
      eDone = 0; wEn = 0; nPend = mPend; wSt = 0; wD = '0; eRd = '0;
      ri = int'(reqIdx); si = int'(snpIdx);
      if (mPend == 0) begin
        if (reqValid && !snpValid) begin
          if (!reqWrite) begin
            if (mSt[ri] != 0) begin eDone = 1; eRd = mD[ri]; end
            else nPend = 2;
          end else if (mSt[ri] >= 2) begin
            eDone = 1; wEn = 1; wSt = 3; wD = reqData;
          end else if (mSt[ri] == 1) nPend = 1;
          else nPend = 3;
        end
      end else if (busAck) begin
        nPend = 0;
        if (mPend == 2) begin
          eDone = 1; eRd = busFillData; wEn = 1; wSt = busFillShared ? 1 : 2; wD = busFillData;
        end else if (mPend == 3) eDone = 1;
        else if (mSt[ri] == 1 && !(snpValid && snpInv && si == ri)) begin
          eDone = 1; wEn = 1; wSt = 3; wD = reqData;
        end
      end
      chk("busReqValid", DW'(busReqValid), DW'(mPend != 0));
      if (mPend != 0) begin
        chk("busReqType", DW'(busReqType), DW'(mPend == 1 ? 0 : (mPend == 2 ? 1 : 2)));
        chk("busReqIdx", DW'(busReqIdx), DW'(reqIdx));
        if (mPend == 3) chk("busReqData", busReqData, reqData);
      end
      chk("localDone", DW'(localDone), DW'(eDone));
      chk("reqBusy", DW'(reqBusy), DW'(reqValid && !eDone));
      if (eDone && !reqWrite) chk("rdData", rdData, eRd);
      chk("snpRespValid", DW'(snpRespValid), DW'(pValid));
      if (pValid) begin
        chk("snpHit", DW'(snpHit), DW'(pHit));
        chk("snpShared", DW'(snpShared), DW'(pShr));
        chk("snpSupply", DW'(snpSupply), DW'(pSup));
        if (pSup) chk("snpData", snpData, pData);
      end
      pValid = snpValid;
      pHit = 0; pShr = 0; pSup = 0; pData = '0;
      if (snpValid) begin
        ss = mSt[si];
        pHit = ss != 0;
        pShr = ss != 0 && !snpInv;
        pSup = ss == 3;
        if (ss == 3) pData = mD[si];
        if (ss != 0) mSt[si] = snpInv ? 0 : 1;
      end
      if (wEn) begin mSt[ri] = wSt; mD[ri] = wD; end
      mPend = nPend;
    end
  end

  // hold a request until done; optionally raise one snoop at cycle offset snpOff
  task automatic doReq(bit w, int idx, logic [DW-1:0] d,
                       int snpOff = -1, bit sInv = 0, int sIdx = 0);
    bit got;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqIdx = IW'(idx); reqData = d;
    for (int k = 0; k < 400; k++) begin
      snpValid = (k == snpOff); snpInv = sInv; snpIdx = IW'(sIdx);
      #1; got = localDone;
      @(negedge clk);
      if (got) break;
    end
    reqValid = 1'b0; snpValid = 1'b0;
  endtask

  task automatic doSnoop(bit inv, int idx);
    @(negedge clk);
    snpValid = 1'b1; snpInv = inv; snpIdx = IW'(idx);
    @(negedge clk);
    snpValid = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL %s watchdog actual=hung expected=finished", phase);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    phase = "R1";
    chk("reset busReqValid", DW'(busReqValid), 0);
    chk("reset snpRespValid", DW'(snpRespValid), 0);
    chk("reset localDone", DW'(localDone), 0);
    @(negedge clk); rstN = 1'b1;

    phase = "R6"; shareNext = 0; doReq(0, 0, '0);        // fill -> E
    phase = "R2"; doReq(0, 0, '0);                        // read hit
    phase = "R3"; doReq(1, 0, 32'hA5A5_0001);             // E write -> M
    doReq(1, 0, 32'hA5A5_0002);                           // M write
    phase = "R2"; doReq(0, 0, '0);
    phase = "R7"; doSnoop(0, 0);                          // M -> S with supply
    phase = "R4"; ackDelay = 3; doReq(1, 0, 32'hB0B0_0003); // S -> own -> M
    phase = "R8"; doSnoop(1, 0);                          // M -> I with supply
    phase = "R9"; doSnoop(1, 0); doSnoop(0, 5);
    phase = "R5"; ackDelay = 0; doReq(1, 1, 32'hC0C0_0004); // direct write
    phase = "R6"; shareNext = 1; doReq(0, 1, '0);          // still I: fill -> S
    phase = "R7"; doSnoop(0, 1);                          // S stays S
    phase = "R11"; ackDelay = 2; doReq(1, 1, 32'hD0D0_0005, 1, 1, 1);
    phase = "R10"; shareNext = 0; doReq(0, 2, '0);
    doReq(1, 2, 32'hE0E0_0006, 0, 0, 2);                  // snoop first: E->S, then own
    phase = "R10"; doReq(0, 3, '0, 0, 0, 6);              // snoop elsewhere still stalls
    phase = "R8"; doSnoop(1, 3);                          // E -> I, no supply
    phase = "R12"; ackDelay = 5; doReq(0, 4, '0);
    phase = "R1";
    for (int i = 0; i < LINES; i++) begin
      ackDelay = i % 3; shareNext = i[0];
      doReq(0, i, '0);
      doReq(1, i, 32'h1234_0000 + i);
      doSnoop(i[1], i);
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule